// File: doc/BRIEF.md
# Multiplier-free modular reducer for the prime 2^64 − 2^32 + 1

This block takes a 128-bit value, usually the full product of two 64-bit residues, and returns its residue modulo the prime p = 2^64 − 2^32 + 1. It uses no multiplier. The input is cut into four 32-bit limbs. Bits [127:96] form the limb a, [95:64] form b, [63:32] form c and [31:0] form d, so x = 2^96·a + 2^64·b + 2^32·c + d.

Two identities hold for this prime: 2^64 ≡ 2^32 − 1 and 2^96 ≡ −1. With them the value collapses to t = 2^32·(b + c) − a − b + d. This folded value always lies strictly between −p and 2p. A final stage forms t + p, t and t − p and keeps the one candidate that falls in [0, p).

The block is a two-stage pipeline: folding, then correction. It accepts one input per clock and tags data with a valid bit. It is generic in the limb width W, with p = 2^(2W) − 2^W + 1. The default is W = 32.

Top module: `solinas_reducer`

## Requirements
- R1: When `out_valid` is high, `out_value` equals `in_value` mod p, where p = 2^(2W) − 2^W + 1 and W = `LIMB_W`. The value always lies in [0, p).
- R2: An input presented with `in_valid` high at clock edge n appears with `out_valid` high after clock edge n+2. A new input is accepted on every edge.
- R3: `out_valid` is high only two edges after an edge where `in_valid` was high. Bubbles in the input stream reappear as bubbles in the output stream.
- R4: While `rst` is high at a clock edge, both pipeline stages clear. After reset, `out_valid` is 0 and `out_value` is 0.
- R5: Limb a (bits [4W−1:3W]) enters with weight −1. An input holding only a = 2^W − 1 therefore yields p − (2^W − 1).
- R6: An input already below p is returned unchanged. Inputs equal to p or to 2p return 0.
- R7: A folded value of p or more is corrected downward by one p. The all-ones input yields (2^(4W) − 1) mod p.
- R8: `out_value` keeps its last result in cycles where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_value` |
| in_value | input | 4·LIMB_W | Value to reduce |
| out_valid | output | 1 | Qualifies `out_value` |
| out_value | output | 2·LIMB_W | Residue modulo p |

## Verification
A wrong fold (a limb in the wrong place, or a sign flipped) gives a residue that differs from x mod p. This shows at the output two cycles after the offending input. It is exposed almost immediately when every 16-bit input of a W = 4 instance is swept, because every limb pattern and every branch of the correction mux is used there.

A wrong correction choice puts a value at or above p, or a wrong residue, on `out_value` in that same cycle. A broken valid path shows as a misplaced `out_valid` pulse, or as a changed held value during bubbles.

// File: rtl/solinas_pkg.sv
package solinas_pkg;

    // default limb width: modulus 2^(2W) - 2^W + 1
    localparam int DEF_LIMB_W = 32;

    // which correction candidate the final stage keeps
    typedef enum logic [1:0] {
        PICK_RAISE = 2'd0,   // t + p   (t negative)
        PICK_KEEP  = 2'd1,   // t       (0 <= t < p)
        PICK_LOWER = 2'd2    // t - p   (p <= t < 2p)
    } pick_e;

endpackage

// File: rtl/solinas_pipe_reg.sv
module solinas_pipe_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/solinas_fold.sv
module solinas_fold #(
    parameter int LIMB_W = solinas_pkg::DEF_LIMB_W
) (
    input  logic [4*LIMB_W-1:0] x,
    output logic [2*LIMB_W+2:0] t
);

    localparam int IN_W   = 4 * LIMB_W;
    localparam int FOLD_W = 2 * LIMB_W + 3;
    localparam int PAD_W  = FOLD_W - LIMB_W;

    // limb[0] = d (least significant) ... limb[3] = a
    logic [LIMB_W-1:0] limb [4];
    logic [FOLD_W-1:0] ext  [4];

    for (genvar gi = 0; gi < 4; gi++) begin : g_split
        assign limb[gi] = x[gi*LIMB_W +: LIMB_W];
        assign ext[gi]  = {{PAD_W{1'b0}}, limb[gi]};
    end

    logic [FOLD_W-1:0] mid_sum;

    always_comb begin
        // 2^(2W) -> 2^W - 1 and 2^(3W) -> -1
        mid_sum = ext[2] + ext[1];
        t = (mid_sum << LIMB_W) - ext[3] - ext[2] + ext[0];
    end

    logic unused_w;
    assign unused_w = (IN_W == 4 * LIMB_W);

endmodule

// File: rtl/solinas_correct.sv
module solinas_correct
    import solinas_pkg::*;
#(
    parameter int LIMB_W = DEF_LIMB_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 vld,
    input  logic [2*LIMB_W+2:0]  t,
    output logic [2*LIMB_W-1:0]  r
);

    localparam int FOLD_W = 2 * LIMB_W + 3;
    localparam int RES_W  = 2 * LIMB_W;
    localparam logic [FOLD_W-1:0] ONE   = FOLD_W'(1);
    localparam logic [FOLD_W-1:0] P_EXT = (ONE << (2 * LIMB_W)) - (ONE << LIMB_W) + ONE;

    logic [FOLD_W-1:0] cand_up;
    logic [FOLD_W-1:0] cand_dn;
    logic [FOLD_W-1:0] chosen;
    pick_e             pick;

    always_comb begin
        cand_up = t + P_EXT;
        cand_dn = t - P_EXT;
        if (t[FOLD_W-1]) begin
            pick = PICK_RAISE;
        end else if (cand_dn[FOLD_W-1]) begin
            pick = PICK_KEEP;
        end else begin
            pick = PICK_LOWER;
        end
        unique case (pick)
            PICK_RAISE: chosen = cand_up;
            PICK_KEEP:  chosen = t;
            default:    chosen = cand_dn;
        endcase
    end

    assign r = chosen[RES_W-1:0];

    // R1: the kept candidate has no bits above the residue width
    res_width_chk: assert property (@(posedge clk) disable iff (rst)
        vld |-> (chosen[FOLD_W-1:RES_W] == '0));

    // R5: a negative fold is lifted into range by a single p
    raise_enough_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && pick == PICK_RAISE) |-> !cand_up[FOLD_W-1]);

    // R7: a fold at or above p drops below p after one subtraction
    lower_enough_chk: assert property (@(posedge clk) disable iff (rst)
        (vld && pick == PICK_LOWER) |-> (cand_dn < P_EXT));

endmodule

// File: rtl/solinas_reducer.sv
module solinas_reducer #(
    parameter int LIMB_W = solinas_pkg::DEF_LIMB_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [4*LIMB_W-1:0]   in_value,
    output logic                  out_valid,
    output logic [2*LIMB_W-1:0]   out_value
);

    localparam int FOLD_W = 2 * LIMB_W + 3;
    localparam int RES_W  = 2 * LIMB_W;
    localparam logic [RES_W:0] ONE_R = (RES_W+1)'(1);
    localparam logic [RES_W:0] P_RES = (ONE_R << (2 * LIMB_W)) - (ONE_R << LIMB_W) + ONE_R;

    // stage 1: fold
    logic [FOLD_W-1:0] fold_d;
    logic [FOLD_W-1:0] fold_q;
    logic              s1_valid;

    solinas_fold #(.LIMB_W(LIMB_W)) u_fold (
        .x (in_value),
        .t (fold_d)
    );

    solinas_pipe_reg #(.WIDTH(FOLD_W)) u_s1_data (
        .clk (clk), .rst (rst), .en (in_valid), .d (fold_d), .q (fold_q)
    );

    solinas_pipe_reg #(.WIDTH(1)) u_s1_vld (
        .clk (clk), .rst (rst), .en (1'b1), .d (in_valid), .q (s1_valid)
    );

    // stage 2: correction
    logic [RES_W-1:0] res_d;

    solinas_correct #(.LIMB_W(LIMB_W)) u_correct (
        .clk (clk),
        .rst (rst),
        .vld (s1_valid),
        .t   (fold_q),
        .r   (res_d)
    );

    solinas_pipe_reg #(.WIDTH(RES_W)) u_s2_data (
        .clk (clk), .rst (rst), .en (s1_valid), .d (res_d), .q (out_value)
    );

    solinas_pipe_reg #(.WIDTH(1)) u_s2_vld (
        .clk (clk), .rst (rst), .en (1'b1), .d (s1_valid), .q (out_valid)
    );

    // R1
    out_lt_p_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ({1'b0, out_value} < P_RES));

    // R3
    valid_origin_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    // R2
    valid_advance_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1_valid);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> $stable(out_value));

endmodule

// File: tb/solinas_reducer_bench.sv
`timescale 1ns/1ps
module solinas_reducer_bench;

    localparam logic [127:0] PB = (128'd1 << 64) - (128'd1 << 32) + 128'd1;
    localparam logic [15:0]  PS = 16'd241;   // W = 4: 256 - 16 + 1

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic         bv;
    logic [127:0] bx;
    logic         bov;
    logic [63:0]  boy;
    logic         sv;
    logic [15:0]  sx;
    logic         sov;
    logic [7:0]   soy;

    solinas_reducer #(.LIMB_W(32)) u_solinas_reducer (
        .clk (clk), .rst (rst), .in_valid (bv), .in_value (bx),
        .out_valid (bov), .out_value (boy)
    );

    solinas_reducer #(.LIMB_W(4)) u_solinas_reducer_small (
        .clk (clk), .rst (rst), .in_valid (sv), .in_value (sx),
        .out_valid (sov), .out_value (soy)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // expected-output history, two deep
    logic        bh1_v, bh2_v, sh1_v, sh2_v;
    logic [63:0] bh1_e, bh2_e, b_last;
    logic [7:0]  sh1_e, sh2_e, s_last;
    string       bh1_r, bh2_r, sh1_r, sh2_r;

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic nbv, input logic [127:0] nbx, input string nbr,
                        input logic nsv, input logic [15:0] nsx, input string nsr);
        @(negedge clk);
        // R2 R3: valid appears exactly two edges after acceptance
        chk(bov == bh2_v, {bh2_r, " R3 valid"}, 128'(bov), 128'(bh2_v));
        chk(sov == sh2_v, {sh2_r, " R3 valid"}, 128'(sov), 128'(sh2_v));
        if (bh2_v) begin
            chk(boy == bh2_e, bh2_r, 128'(boy), 128'(bh2_e));
            b_last = bh2_e;
        end else begin
            chk(boy == b_last, "R8 hold", 128'(boy), 128'(b_last));
        end
        if (sh2_v) begin
            chk(soy == sh2_e, sh2_r, 128'(soy), 128'(sh2_e));
            s_last = sh2_e;
        end else begin
            chk(soy == s_last, "R8 hold", 128'(soy), 128'(s_last));
        end
        bh2_v = bh1_v; bh2_e = bh1_e; bh2_r = bh1_r;
        sh2_v = sh1_v; sh2_e = sh1_e; sh2_r = sh1_r;
        bh1_v = nbv;   bh1_e = 64'(nbx % PB); bh1_r = nbr;
        sh1_v = nsv;   sh1_e = 8'(nsx % PS);  sh1_r = nsr;
        bv = nbv; bx = nbx;
        sv = nsv; sx = nsx;
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    initial begin
        bv = 1'b1; bx = '1; sv = 1'b1; sx = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0; bv = 1'b0; sv = 1'b0;
        bh1_v = 0; bh2_v = 0; sh1_v = 0; sh2_v = 0;
        bh1_e = '0; bh2_e = '0; sh1_e = '0; sh2_e = '0;
        bh1_r = "R4"; bh2_r = "R4"; sh1_r = "R4"; sh2_r = "R4";
        b_last = '0; s_last = '0;
        @(negedge clk);
        // R4: reset state
        chk(bov == 1'b0 && boy == '0, "R4 reset", {bov, boy}, 128'd0);
        chk(sov == 1'b0 && soy == '0, "R4 reset small", {sov, soy}, 128'd0);

        // edge cases on the 32-bit-limb instance
        tick(1, '0,                 "R6 zero",      0, '0, "R4");
        tick(1, '1,                 "R7 all-ones",  0, '0, "R4");
        tick(1, {32'hFFFF_FFFF, 96'd0}, "R5 a-only", 0, '0, "R4");
        tick(1, PB,                 "R6 equal p",   0, '0, "R4");
        tick(1, PB << 1,            "R6 equal 2p",  0, '0, "R4");
        tick(1, PB - 128'd1,        "R6 p-1",       0, '0, "R4");
        tick(1, (PB << 1) - 128'd1, "R1 2p-1",      0, '0, "R4");
        tick(1, {32'd0, 32'hFFFF_FFFF, 64'd0}, "R1 b-only", 0, '0, "R4");
        tick(0, '0, "R3", 0, '0, "R4");
        tick(0, '0, "R3", 0, '0, "R4");
        tick(0, '0, "R3", 0, '0, "R4");

        // random stream with bubbles
        for (int i = 0; i < 3000; i++) begin
            tick(($urandom() % 4) != 0, rnd128(), "R1 random", 0, '0, "R4");
        end
        // back-to-back random, full rate
        for (int i = 0; i < 1000; i++) begin
            tick(1, rnd128(), "R2 stream", 0, '0, "R4");
        end
        tick(0, '0, "R3", 0, '0, "R4");
        tick(0, '0, "R3", 0, '0, "R4");

        // exhaustive sweep on the W = 4 instance, p = 241
        for (int i = 0; i < 65536; i++) begin
            tick(0, '0, "R3", 1, 16'(i), "R1 sweep");
        end
        tick(0, '0, "R3", 0, '0, "R8");
        tick(0, '0, "R3", 1, 16'hF000, "R5 small a-only");
        tick(0, '0, "R3", 0, '0, "R8");
        tick(0, '0, "R3", 0, '0, "R8");
        tick(0, '0, "R3", 0, '0, "R8");

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule